// File: doc/BRIEF.md
# Rewindable FIFO with Half-Full Flag

This block is a 9-bit-wide first-in first-out buffer whose depth is a power-of-two parameter between 256 and 8192 words. All activity is synchronous to one clock. A producer stores a word by holding an active-low write strobe low for a cycle. A consumer takes the oldest word by holding an active-low read strobe low for a cycle. The word appears on the data output one cycle later, and a one-cycle valid pulse qualifies it. Three active-low flags report occupancy: full, empty, and more-than-half-full.

A rewind input lets the consumer read again what has already been stored. When the rewind input is low and both strobes are idle, the read position returns to location zero and the write position is left alone. Every word written since reset is then available again, in its original order. This is useful when a block of fewer than DEPTH words must be played out more than once. The flags follow the new read-to-write distance.

Top module: `rewind_fifo`

## Requirements
- R1: While the active-low reset is held and after it is released, with no strobe accepted, the buffer holds zero words: empty_n is 0, full_n is 1, half_n is 1 and rd_vld is 0.
- R2: A write strobe while full_n is 0 and no read is accepted in that cycle is discarded: full_n stays 0 and the stored words are not overwritten.
- R3: A read strobe while empty_n is 0 is discarded: rd_vld stays 0 in the following cycle and no stored word is consumed.
- R4: empty_n is 0 exactly when the stored count is zero. It rises in the cycle after the first accepted write into an empty buffer.
- R5: full_n is 0 exactly when the stored count equals DEPTH. Starting from reset, it falls after DEPTH accepted writes with no reads, and it rises in the cycle after the next accepted read.
- R6: half_n is 0 exactly when the stored count exceeds DEPTH/2. It falls on the write that takes the count above DEPTH/2 and rises on the read that brings the count to DEPTH/2 or fewer.
- R7: A cycle with rtx_n at 0 and both wr_n and rd_n at 1 moves the read position to location zero and leaves the write position unchanged. If at most DEPTH writes have occurred since reset, the following reads return every word written since reset, in write order, and the flags reflect that count.
- R8: rtx_n at 0 in a cycle where wr_n or rd_n is 0 has no rewind effect. The strobes in that cycle act as they would with rtx_n at 1.
- R9: Words are read out in the order they were accepted. A read and a write accepted in the same cycle leave the stored count unchanged.
- R10: While full, a cycle with both strobes low accepts the read and the write. The buffer stays full and the new word is kept behind the older ones.
- R11: rd_vld is 1 in the cycle after an accepted read, with the read word on rd_data, and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe |
| wr_data | input | DATA_W | Word to store |
| rd_n | input | 1 | Active-low read strobe |
| rtx_n | input | 1 | Active-low rewind request |
| rd_data | output | DATA_W | Word read out |
| rd_vld | output | 1 | rd_data qualifier, one cycle per accepted read |
| full_n | output | 1 | Low when DEPTH words are stored |
| empty_n | output | 1 | Low when no word is stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |

## Verification
The hardest state to reach is a full buffer that is rewound and then read and written in the same cycle. Reaching it needs exactly DEPTH writes with no intervening read, a few reads to open space, a rewind that restores full occupancy from location zero, and then combined read-and-write strobes. The stimulus follows that path directly after a fresh reset, while the write count since reset is still DEPTH, so the model's replay list stays valid. Writes issued while full, and rewinds issued alongside a strobe, are then exposed by the ordered comparison of later read data.

// File: rtl/rewind_fifo_pkg.sv
package rewind_fifo_pkg;

    // Operations granted in one cycle.
    typedef struct packed {
        logic wr;
        logic rd;
        logic rew;
    } fifo_ops_t;

endpackage

// File: rtl/rewind_fifo_ram.sv
module rewind_fifo_ram #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 256,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    // The read register samples the old word when the read and write
    // addresses collide (full buffer, simultaneous read and write).
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/rewind_fifo_flags.sv
module rewind_fifo_flags #(
    parameter int DEPTH = 256,
    parameter int PTR_W = 9
) (
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic             is_full,
    output logic             is_empty,
    output logic             over_half
);

    logic [PTR_W-1:0] occ;

    // The extra wrap bit makes the difference range 0..DEPTH.
    assign occ       = wr_ptr - rd_ptr;
    assign is_full   = (occ == PTR_W'(DEPTH));
    assign is_empty  = (occ == '0);
    assign over_half = (occ > PTR_W'(DEPTH / 2));

endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
    import rewind_fifo_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_n,
    input  logic              rtx_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_vld,
    output logic              full_n,
    output logic              empty_n,
    output logic              half_n
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PTR_W  = ADDR_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic             vld;
    } state_t;

    state_t    state_d, state_q;
    fifo_ops_t ops;
    logic      is_full, is_empty, over_half;

    rewind_fifo_flags #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W)
    ) u_flags (
        .wr_ptr    (state_q.wp),
        .rd_ptr    (state_q.rp),
        .is_full   (is_full),
        .is_empty  (is_empty),
        .over_half (over_half)
    );

    always_comb begin
        ops.rd  = !rd_n && !is_empty;
        ops.wr  = !wr_n && (!is_full || ops.rd);
        ops.rew = !rtx_n && rd_n && wr_n;

        state_d     = state_q;
        state_d.vld = ops.rd;
        if (ops.wr) state_d.wp = state_q.wp + PTR_W'(1);
        if (ops.rew)
            state_d.rp = '0;
        else if (ops.rd)
            state_d.rp = state_q.rp + PTR_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    rewind_fifo_ram #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_ram (
        .clk   (clk),
        .we    (ops.wr),
        .waddr (state_q.wp[ADDR_W-1:0]),
        .wdata (wr_data),
        .re    (ops.rd),
        .raddr (state_q.rp[ADDR_W-1:0]),
        .rdata (rd_data)
    );

    assign rd_vld  = state_q.vld;
    assign full_n  = !is_full;
    assign empty_n = !is_empty;
    assign half_n  = !over_half;

endmodule

// File: rtl/rewind_fifo_chk.sv
module rewind_fifo_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_n,
    input logic rd_n,
    input logic rtx_n,
    input logic rd_vld,
    input logic full_n,
    input logic empty_n,
    input logic half_n
);

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!empty_n && full_n && half_n && !rd_vld)); // R1

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !wr_n && rd_n) |=> !full_n); // R2

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && !rd_n) |=> !rd_vld); // R3

    AST_FIRST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && !wr_n) |=> empty_n); // R4

    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !(!full_n && !empty_n)); // R5

    AST_HALF_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !half_n); // R6

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n && wr_n && rtx_n) |=> ($stable(empty_n) && $stable(full_n) && $stable(half_n))); // R9

    AST_FULL_RW: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !rd_n && !wr_n) |=> (!full_n && rd_vld)); // R10

    AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |=> !rd_vld); // R11

endmodule

bind rewind_fifo rewind_fifo_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_n    (wr_n),
    .rd_n    (rd_n),
    .rtx_n   (rtx_n),
    .rd_vld  (rd_vld),
    .full_n  (full_n),
    .empty_n (empty_n),
    .half_n  (half_n)
);

// File: tb/rewind_fifo_tb.sv
`timescale 1ns/1ps
module rewind_fifo_tb;

    localparam int DW    = 9;
    localparam int DEPTH = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_n = 1'b1, rd_n = 1'b1, rtx_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          rd_vld, full_n, empty_n, half_n;

    always #4 clk = ~clk; // 125 MHz

    rewind_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .wr_data(wr_data),
        .rd_n(rd_n), .rtx_n(rtx_n), .rd_data(rd_data), .rd_vld(rd_vld),
        .full_n(full_n), .empty_n(empty_n), .half_n(half_n)
    );

    typedef struct {
        logic [DW-1:0] d;
        string         tag;
    } exp_t;

    int            n_chk = 0;
    int            n_fail = 0;
    exp_t          sb_q[$];      // words the monitor expects next
    logic [DW-1:0] mq[$];        // model contents
    logic [DW-1:0] hist[DEPTH];  // words written since reset
    int            wr_total = 0;
    int            cnt = 0;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus; the model decides what is accepted.
    task automatic step(bit w, bit r, bit rt, logic [DW-1:0] d, string tag);
        bit r_ok, w_ok, rt_ok;
        wr_n    = !w;
        rd_n    = !r;
        rtx_n   = !rt;
        wr_data = d;
        r_ok  = r && (cnt > 0);
        w_ok  = w && ((cnt < DEPTH) || r_ok);
        rt_ok = rt && !w && !r;
        if (r_ok) begin
            sb_q.push_back('{mq.pop_front(), tag});
            cnt--;
        end
        if (w_ok) begin
            mq.push_back(d);
            if (wr_total < DEPTH) hist[wr_total] = d;
            wr_total++;
            cnt++;
        end
        if (rt_ok) begin
            mq.delete();
            for (int i = 0; i < wr_total; i++) mq.push_back(hist[i]);
            cnt = wr_total;
        end
        @(posedge clk);
        @(negedge clk);
        chk(rd_vld == r_ok, "R11", "rd_vld", int'(rd_vld), int'(r_ok));
        chk(empty_n == (cnt != 0), "R4", "empty_n", int'(empty_n), int'(cnt != 0));
        chk(full_n == (cnt != DEPTH), "R5", "full_n", int'(full_n), int'(cnt != DEPTH));
        chk(half_n == (cnt <= DEPTH / 2), "R6", "half_n", int'(half_n), int'(cnt <= DEPTH / 2));
    endtask

    task automatic do_reset();
        wr_n  = 1'b1;
        rd_n  = 1'b1;
        rtx_n = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!empty_n && full_n && half_n && !rd_vld, "R1", "flags in reset", 0, 0);
        sb_q.delete();
        mq.delete();
        wr_total = 0;
        cnt = 0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(empty_n == 1'b0, "R1", "empty_n", int'(empty_n), 0);
        chk(full_n == 1'b1, "R1", "full_n", int'(full_n), 1);
        chk(half_n == 1'b1, "R1", "half_n", int'(half_n), 1);
        chk(rd_vld == 1'b0, "R1", "rd_vld", int'(rd_vld), 0);
    endtask

    // Monitor: scoreboard comparison of every valid output word.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && rd_vld) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R3", "unexpected rd_vld", 1, 0);
            end else begin
                e = sb_q.pop_front();
                chk(rd_data === e.d, e.tag, "rd_data", int'(rd_data), int'(e.d));
            end
        end
    end

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog expired: actual 1 expected 0");
        summary();
        $finish;
    end

    initial begin
        do_reset();

        // R3: read of an empty buffer is discarded
        step(0, 1, 0, '0, "R3");
        chk(rd_vld == 1'b0, "R3", "rd_vld after empty read", int'(rd_vld), 0);

        // R4: first write clears empty, read returns it
        step(1, 0, 0, 9'h1A5, "R4");
        step(0, 1, 0, '0, "R9");

        for (int i = 0; i < 10; i++) step(1, 0, 0, DW'(i * 7 + 3), "R9");
        for (int i = 0; i < 4; i++) step(0, 1, 0, '0, "R9");

        // R8: rewind alongside a strobe has no rewind effect
        step(0, 1, 1, '0, "R8");
        step(1, 0, 1, 9'h055, "R8");
        step(0, 0, 0, '0, "R8");

        // R7: rewind replays everything since reset
        step(0, 0, 1, '0, "R7");
        chk(cnt == 12, "R7", "model count", cnt, 12);
        while (cnt > 0) step(0, 1, 0, '0, "R7");
        step(0, 1, 0, '0, "R3");

        // R9: simultaneous read and write keep the count
        for (int i = 0; i < 3; i++) step(1, 0, 0, DW'(9'h100 + i), "R9");
        for (int i = 0; i < 5; i++) step(1, 1, 0, DW'(9'h0F0 + i), "R9");
        chk(empty_n == 1'b1, "R9", "still occupied", int'(empty_n), 1);
        while (cnt > 0) step(0, 1, 0, '0, "R9");

        // R5/R6: fill from reset
        do_reset();
        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, DW'(i * 3 + 1), "R6");
        chk(full_n == 1'b0, "R5", "full after DEPTH writes", int'(full_n), 0);

        // R2: writes while full are discarded
        for (int i = 0; i < 3; i++) step(1, 0, 0, 9'h1FF, "R2");

        // R7 on a full buffer
        for (int i = 0; i < 3; i++) step(0, 1, 0, '0, "R5");
        step(0, 0, 1, '0, "R7");
        chk(full_n == 1'b0, "R7", "full after rewind", int'(full_n), 0);

        // R10: read and write together while full
        step(1, 1, 0, 9'h0AA, "R10");
        chk(full_n == 1'b0, "R10", "full kept", int'(full_n), 0);
        step(1, 1, 0, 9'h0BB, "R10");

        // R5: one read releases full
        step(0, 1, 0, '0, "R5");
        chk(full_n == 1'b1, "R5", "full released", int'(full_n), 1);

        // Mixed traffic
        for (int i = 0; i < 3000; i++)
            step(bit'($urandom % 2), bit'($urandom % 2), 1'b0, DW'($urandom), "R9");
        while (cnt > 0) step(0, 1, 0, '0, "R9");
        step(0, 0, 0, '0, "R9");
        chk(sb_q.size() == 0, "R11", "missing read words", sb_q.size(), 0);

        summary();
        $finish;
    end

endmodule